// File: doc/BRIEF.md
# DMA Coherence Request Controller

This block is the front end of a DMA engine that sits on a directory-based coherent memory system and keeps one transaction in flight at a time. It takes load and store requests from a DMA sequencer. For each one it sends a DMA read or DMA write request to the directory, and it stays busy until the transaction is resolved. A read is resolved when a data response arrives, or when the pending-ack count returns to zero. A write is resolved when the pending-ack count returns to zero. The sequencer then receives the read data or a write-done pulse.

The transaction entry keeps the address and a data block, and a signed pending-ack counter sits beside it. Invalidation acks from sharers and the directory's own ack each subtract the count they carry, in whichever order they arrive. The directory ack may carry a negative field, which raises the count. When the counter lands on zero, an internal trigger is raised. One cycle later the controller consumes that trigger, finishes the transaction and, on a write, sends an exclusive-unblock response to the directory. Both directory-bound outputs pass through fixed latency lines. A sticky error output flags responses that the current state cannot use.

Top module: `dma_coh_ctrl`

## Requirements
- R1: After reset the controller is idle. `seq_ready` is 1, while `rd_done`, `wr_done`, `dreq_valid`, `unblk_valid` and `proto_err` are all 0.
- R2: A load (`seq_is_store`=0) accepted in cycle c produces `dreq_valid` in cycle c+REQ_LAT. That request has `dreq_is_write`=0 and carries the accepted address and length, with `dreq_src`=SRC_ID.
- R3: A store (`seq_is_store`=1) accepted in cycle c produces `dreq_valid` in cycle c+REQ_LAT. That request has `dreq_is_write`=1 and carries the accepted address, data and length.
- R4: While a read is outstanding, a response of kind 0 (data) or 1 (exclusive data) consumed in cycle c raises `rd_done` in cycle c+1, with `rd_data` equal to the response data. The controller is idle again from that cycle.
- R5: An invalidation ack (kind 2) in either busy state subtracts `rsp_acks`, read as a two's-complement number, from the signed pending counter. If the result is zero, the transaction completes through the trigger one cycle after the ack is consumed.
- R6: A directory ack (kind 3) during a write subtracts its signed `rsp_acks` field, so a negative field raises the count. A write completes only when the count reaches zero, whether the directory ack comes before, between or after the invalidation acks. No `wr_done` appears earlier.
- R7: For a write, if the final ack is consumed in cycle c, then the trigger is consumed in cycle c+1. `wr_done` pulses in cycle c+2. `unblk_valid` appears in cycle c+1+RSP_LAT, carrying the transaction address.
- R8: When a read completes through the trigger, `rd_data` returns the data block stored in the entry, which is the `seq_data` captured when the load was accepted.
- R9: While busy, `seq_ready` is 0. A held sequencer request is not dropped: it is accepted once the controller is idle again.
- R10: Only one message is consumed per cycle. A pending trigger blocks responses (`rsp_ready`=0), and a valid response blocks the sequencer (`seq_ready`=0).
- R11: A response of an unknown kind (4 to 7) or a kind that the current state cannot use is consumed. It sets `proto_err`, which then stays 1 until reset, and the controller state does not change.
- R12: The pending counter is cleared to zero when a request is accepted. The trigger completes each transaction exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_valid | input | 1 | Sequencer request present |
| seq_ready | output | 1 | Sequencer request consumed this cycle when valid |
| seq_is_store | input | 1 | 1 = store, 0 = load |
| seq_addr | input | ADDR_W | Request address |
| seq_data | input | DATA_W | Request data block |
| seq_len | input | LEN_W | Request length |
| rsp_valid | input | 1 | Directory response present |
| rsp_ready | output | 1 | Response consumed this cycle when valid |
| rsp_kind | input | 3 | 0 data, 1 exclusive data, 2 invalidation ack, 3 directory ack |
| rsp_acks | input | ACK_W | Signed ack count carried by the response |
| rsp_data | input | DATA_W | Response data block |
| dreq_valid | output | 1 | Delayed request to the directory |
| dreq_is_write | output | 1 | 1 = DMA write, 0 = DMA read |
| dreq_addr | output | ADDR_W | Request address |
| dreq_data | output | DATA_W | Request data block |
| dreq_len | output | LEN_W | Request length |
| dreq_src | output | ID_W | Requestor identifier |
| unblk_valid | output | 1 | Delayed exclusive-unblock response |
| unblk_addr | output | ADDR_W | Address of the unblocked line |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Read data returned to the sequencer |
| wr_done | output | 1 | One-cycle write completion pulse |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with REQ_LAT=3, RSP_LAT=5 and SRC_ID=9, keeping ADDR_W=32, DATA_W=64 and ACK_W=8. The short latencies let every outgoing request and unblock be checked at its exact cycle. They also keep many transactions within a short run. Random writes use up to three sharers, and the directory ack is placed at every possible position among the invalidation acks. This drives the counter negative, positive and back to zero. Directed cases cover the stalled request, a response that does not match the state, an unknown kind racing a sequencer request, and a read closed through a zero-count ack.

// File: rtl/dcc_pkg.sv
// Shared types and response-kind codes for the DMA coherence request controller.
package dcc_pkg;
    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_BUSY_RD = 2'd1,
        ST_BUSY_WR = 2'd2
    } dcc_state_t;

    localparam logic [2:0] KIND_DATA      = 3'd0;
    localparam logic [2:0] KIND_DATA_EXCL = 3'd1;
    localparam logic [2:0] KIND_INV_ACK   = 3'd2;
    localparam logic [2:0] KIND_DIR_ACK   = 3'd3;
endpackage

// File: rtl/dcc_delay.sv
// Fixed-latency message line: a message presented in cycle c appears on the
// output in cycle c+LAT. It assumes one message per cycle at most and no
// back-pressure. LAT=0 gives a wire.
module dcc_delay #(
    parameter int W   = 8,
    parameter int LAT = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    generate
        if (LAT == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_pipe
            logic [LAT-1:0] vld;
            logic [W-1:0]   dat [LAT];

            // Shift valid bits; reset empties the line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld <= '0;
                end else begin
                    vld[0] <= in_valid;
                    for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
                end
            end

            // Shift payload alongside; payload needs no reset.
            always_ff @(posedge clk) begin
                dat[0] <= in_data;
                for (int i = 1; i < LAT; i++) dat[i] <= dat[i-1];
            end

            assign out_valid = vld[LAT-1];
            assign out_data  = dat[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/dcc_ack_tracker.sv
// Signed pending-ack counter with the internal all-acks trigger. The counter
// is cleared on accept and decremented by each signed ack field. When the
// result is zero, the trigger is raised for the next cycle. It assumes the
// owner never subtracts while the trigger is pending.
module dcc_ack_tracker #(
    parameter int ACK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sub_en,
    input  logic [ACK_W-1:0] sub_val,
    input  logic             take,
    output logic             trig_pend
);
    logic signed [ACK_W-1:0] count;
    logic signed [ACK_W-1:0] count_nxt;

    assign count_nxt = count - $signed(sub_val);

    // Hold the pending count for the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (sub_en)     count <= count_nxt;
    end

    // Queue the trigger when an update lands on zero; drop it once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || take)        trig_pend <= 1'b0;
        else if (sub_en && count_nxt == '0) trig_pend <= 1'b1;
    end

    AST_TRIG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pend |-> count == '0); // R5
    AST_TRIG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !trig_pend); // R12
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !trig_pend)); // R12
endmodule

// File: rtl/dma_coh_ctrl.sv
// Single-outstanding DMA coherence request controller. It accepts sequencer
// loads and stores and sends delayed directory requests. It resolves each
// transaction from data or from ack counting, and returns data or a
// write-done pulse. After a write it sends a delayed exclusive unblock.
// Assumptions: each input message is held until its ready is seen; the
// trigger beats responses and responses beat new requests.
module dma_coh_ctrl
    import dcc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int LEN_W   = 8,
    parameter int ACK_W   = 8,
    parameter int ID_W    = 4,
    parameter int REQ_LAT = 14,
    parameter int RSP_LAT = 14,
    parameter logic [ID_W-1:0] SRC_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_valid,
    output logic              seq_ready,
    input  logic              seq_is_store,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [DATA_W-1:0] seq_data,
    input  logic [LEN_W-1:0]  seq_len,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [2:0]        rsp_kind,
    input  logic [ACK_W-1:0]  rsp_acks,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              dreq_valid,
    output logic              dreq_is_write,
    output logic [ADDR_W-1:0] dreq_addr,
    output logic [DATA_W-1:0] dreq_data,
    output logic [LEN_W-1:0]  dreq_len,
    output logic [ID_W-1:0]   dreq_src,
    output logic              unblk_valid,
    output logic [ADDR_W-1:0] unblk_addr,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done,
    output logic              proto_err
);
    localparam int REQ_W = 1 + ADDR_W + DATA_W + LEN_W;

    dcc_state_t        state;
    logic [ADDR_W-1:0] tbe_addr;
    logic [DATA_W-1:0] tbe_data;
    logic              trig_pend;
    logic              take_trig, take_rsp, take_seq;
    logic              is_data, is_inv, is_dack, rsp_fits, sub_en;
    logic [REQ_W-1:0]  req_pkt, req_out;

    // Arbitration: trigger, then response, then sequencer.
    assign take_trig = trig_pend && (state != ST_READY);
    assign rsp_ready = !trig_pend;
    assign take_rsp  = rsp_valid && rsp_ready;
    assign seq_ready = (state == ST_READY) && !trig_pend && !rsp_valid;
    assign take_seq  = seq_valid && seq_ready;

    // Response decode and legality for the current state.
    always_comb begin
        is_data  = (rsp_kind == KIND_DATA) || (rsp_kind == KIND_DATA_EXCL);
        is_inv   = (rsp_kind == KIND_INV_ACK);
        is_dack  = (rsp_kind == KIND_DIR_ACK);
        rsp_fits = (is_data && state == ST_BUSY_RD)
                 || (is_inv && state != ST_READY)
                 || (is_dack && state == ST_BUSY_WR);
    end

    assign sub_en = take_rsp && (is_inv || is_dack) && rsp_fits;

    dcc_ack_tracker #(.ACK_W(ACK_W)) u_acks (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take_seq),
        .sub_en   (sub_en),
        .sub_val  (rsp_acks),
        .take     (take_trig),
        .trig_pend(trig_pend)
    );

    // Controller state, transaction entry and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READY;
            tbe_addr <= '0;
            tbe_data <= '0;
            rd_done  <= 1'b0;
            rd_data  <= '0;
            wr_done  <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            wr_done <= 1'b0;
            case (state)
                ST_READY: begin
                    if (take_seq) begin
                        tbe_addr <= seq_addr;
                        tbe_data <= seq_data;
                        state    <= seq_is_store ? ST_BUSY_WR : ST_BUSY_RD;
                    end
                end
                ST_BUSY_RD: begin
                    if (take_trig) begin
                        rd_done <= 1'b1;
                        rd_data <= tbe_data;
                        state   <= ST_READY;
                    end else if (take_rsp && is_data) begin
                        tbe_data <= rsp_data;
                        rd_done  <= 1'b1;
                        rd_data  <= rsp_data;
                        state    <= ST_READY;
                    end
                end
                ST_BUSY_WR: begin
                    if (take_trig) begin
                        wr_done <= 1'b1;
                        state   <= ST_READY;
                    end
                end
                default: state <= ST_READY;
            endcase
        end
    end

    // Sticky protocol error on any consumed response the state cannot use.
    always_ff @(posedge clk) begin
        if (!rst_n)                    proto_err <= 1'b0;
        else if (take_rsp && !rsp_fits) proto_err <= 1'b1;
    end

    assign req_pkt = {seq_is_store, seq_addr, seq_data, seq_len};

    dcc_delay #(.W(REQ_W), .LAT(REQ_LAT)) u_req_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (take_seq),
        .in_data  (req_pkt),
        .out_valid(dreq_valid),
        .out_data (req_out)
    );

    assign {dreq_is_write, dreq_addr, dreq_data, dreq_len} = req_out;
    assign dreq_src = SRC_ID;

    dcc_delay #(.W(ADDR_W), .LAT(RSP_LAT)) u_unblk_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (take_trig && state == ST_BUSY_WR),
        .in_data  (tbe_addr),
        .out_valid(unblk_valid),
        .out_data (unblk_addr)
    );

    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY) |-> !seq_ready); // R9
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_trig, take_rsp, take_seq})); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R11
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && wr_done)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done || wr_done) |-> state == ST_READY); // R4
    AST_BAD_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rsp && !rsp_fits) |=> $stable(state)); // R11
endmodule

// File: tb/dma_coh_ctrl_bench.sv
`timescale 1ns/1ps
module dma_coh_ctrl_bench;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 64;
    localparam int LEN_W   = 8;
    localparam int ACK_W   = 8;
    localparam int ID_W    = 4;
    localparam int REQ_LAT = 3;
    localparam int RSP_LAT = 5;
    localparam logic [ID_W-1:0] SRC_ID = 4'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_valid = 1'b0, seq_is_store = 1'b0;
    logic [ADDR_W-1:0] seq_addr = '0;
    logic [DATA_W-1:0] seq_data = '0;
    logic [LEN_W-1:0]  seq_len = '0;
    logic rsp_valid = 1'b0;
    logic [2:0] rsp_kind = '0;
    logic [ACK_W-1:0] rsp_acks = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic seq_ready, rsp_ready, dreq_valid, dreq_is_write, unblk_valid;
    logic rd_done, wr_done, proto_err;
    logic [ADDR_W-1:0] dreq_addr, unblk_addr;
    logic [DATA_W-1:0] dreq_data, rd_data;
    logic [LEN_W-1:0]  dreq_len;
    logic [ID_W-1:0]   dreq_src;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_coh_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ACK_W(ACK_W),
        .ID_W(ID_W), .REQ_LAT(REQ_LAT), .RSP_LAT(RSP_LAT), .SRC_ID(SRC_ID)
    ) u_dma_coh_ctrl (
        .clk(clk), .rst_n(rst_n),
        .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_is_store(seq_is_store),
        .seq_addr(seq_addr), .seq_data(seq_data), .seq_len(seq_len),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_acks(rsp_acks), .rsp_data(rsp_data),
        .dreq_valid(dreq_valid), .dreq_is_write(dreq_is_write), .dreq_addr(dreq_addr),
        .dreq_data(dreq_data), .dreq_len(dreq_len), .dreq_src(dreq_src),
        .unblk_valid(unblk_valid), .unblk_addr(unblk_addr),
        .rd_done(rd_done), .rd_data(rd_data), .wr_done(wr_done), .proto_err(proto_err)
    );

    // Directory ack field that balances k invalidation acks of one each.
    function automatic logic [ACK_W-1:0] dir_ack_field(input int k);
        return ACK_W'(-k);
    endfunction

    // Read data expected: response data on a data close, entry data otherwise.
    function automatic logic [DATA_W-1:0] exp_rd(input bit via_ack,
            input logic [DATA_W-1:0] req_d, input logic [DATA_W-1:0] rsp_d);
        return via_ack ? req_d : rsp_d;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send_seq(input bit st, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d, input logic [LEN_W-1:0] l);
        @(negedge clk);
        seq_valid = 1'b1; seq_is_store = st; seq_addr = a; seq_data = d; seq_len = l;
        while (!seq_ready) @(negedge clk);
        @(posedge clk); #1;
        seq_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic [2:0] kd, input logic [ACK_W-1:0] ak,
                            input logic [DATA_W-1:0] d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = kd; rsp_acks = ak; rsp_data = d;
        while (!rsp_ready) @(negedge clk);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
    endtask

    task automatic chk_req(input string tag, input bit st, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input logic [LEN_W-1:0] l);
        repeat (REQ_LAT) @(negedge clk);
        chk(tag, "dreq_valid", 64'(dreq_valid), 64'd1);
        chk(tag, "dreq_is_write", 64'(dreq_is_write), 64'(st));
        chk(tag, "dreq_addr", 64'(dreq_addr), 64'(a));
        chk(tag, "dreq_len", 64'(dreq_len), 64'(l));
        chk(tag, "dreq_src", 64'(dreq_src), 64'(SRC_ID));
        if (st) chk(tag, "dreq_data", dreq_data, d);
    endtask

    // Write with k sharers, directory ack placed at position p among them.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic [LEN_W-1:0] l, input int k, input int p);
        send_seq(1'b1, a, d, l);
        chk_req("R3", 1'b1, a, d, l);
        for (int i = 0; i <= k; i++) begin
            if (i == p) send_rsp(3'd3, dir_ack_field(k), '0);
            else        send_rsp(3'd2, ACK_W'(1), '0);
            if (i != k) begin
                @(negedge clk);
                chk("R6", "early wr_done", 64'(wr_done), 64'd0);
            end
        end
        @(negedge clk);
        chk("R10", "rsp_ready with trigger pending", 64'(rsp_ready), 64'd0);
        chk("R7", "wr_done before trigger", 64'(wr_done), 64'd0);
        @(negedge clk);
        chk("R7", "wr_done", 64'(wr_done), 64'd1);
        repeat (RSP_LAT - 1) @(negedge clk);
        chk("R7", "unblk_valid", 64'(unblk_valid), 64'd1);
        chk("R7", "unblk_addr", 64'(unblk_addr), 64'(a));
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic [LEN_W-1:0] l, input bit via_ack,
                           input logic [DATA_W-1:0] rd, input bit excl);
        send_seq(1'b0, a, d, l);
        chk_req("R2", 1'b0, a, d, l);
        if (!via_ack) begin
            send_rsp(excl ? 3'd1 : 3'd0, '0, rd);
            @(negedge clk);
            chk("R4", "rd_done", 64'(rd_done), 64'd1);
            chk("R4", "rd_data", rd_data, exp_rd(1'b0, d, rd));
        end else begin
            send_rsp(3'd2, '0, '0);
            @(negedge clk);
            chk("R5", "rd_done before trigger", 64'(rd_done), 64'd0);
            @(negedge clk);
            chk("R8", "rd_done", 64'(rd_done), 64'd1);
            chk("R8", "rd_data", rd_data, exp_rd(1'b1, d, rd));
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "seq_ready", 64'(seq_ready), 64'd1);
        chk("R1", "proto_err", 64'(proto_err), 64'd0);
        chk("R1", "rd_done", 64'(rd_done), 64'd0);
        chk("R1", "wr_done", 64'(wr_done), 64'd0);
        chk("R1", "dreq_valid", 64'(dreq_valid), 64'd0);
        chk("R1", "unblk_valid", 64'(unblk_valid), 64'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();

        // Directed: plain write, write with sharers in both orders, reads.
        do_write(32'h0000_1000, 64'hDEAD_BEEF_0000_0001, 8'd64, 0, 0);
        do_write(32'h0000_2040, 64'h1111_2222_3333_4444, 8'd32, 2, 0);
        do_write(32'h0000_3080, 64'h5555_6666_7777_8888, 8'd16, 3, 3);
        do_read(32'h0000_4000, 64'hAAAA_0000_0000_0001, 8'd8, 1'b0, 64'hC0FF_EE00_1234_5678, 1'b0);
        do_read(32'h0000_5000, 64'h0BAD_F00D_0000_0002, 8'd4, 1'b1, '0, 1'b0);

        // Random mix.
        for (int t = 0; t < 60; t++) begin
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d, rd;
            logic [LEN_W-1:0]  l;
            int k;
            a  = $urandom();
            d  = {$urandom(), $urandom()};
            rd = {$urandom(), $urandom()};
            l  = LEN_W'($urandom());
            k  = int'($urandom_range(3, 0));
            if ($urandom_range(1, 0) == 1)
                do_write(a, d, l, k, int'($urandom_range(k, 0)));
            else
                do_read(a, d, l, $urandom_range(3, 0) == 0, rd, $urandom_range(1, 0) == 1);
        end

        // R9: request held during a write is stalled, then accepted.
        send_seq(1'b1, 32'h0000_6000, 64'h6, 8'd2);
        repeat (REQ_LAT) @(negedge clk);
        seq_valid = 1'b1; seq_is_store = 1'b0; seq_addr = 32'h0000_7000;
        seq_data = 64'h7; seq_len = 8'd3;
        #1;
        chk("R9", "seq_ready while busy", 64'(seq_ready), 64'd0);
        send_rsp(3'd3, '0, '0);
        @(negedge clk);
        chk("R9", "seq_ready during trigger", 64'(seq_ready), 64'd0);
        @(negedge clk);
        chk("R9", "held request accepted", 64'(seq_ready), 64'd1);
        @(posedge clk); #1;
        seq_valid = 1'b0;
        chk_req("R9", 1'b0, 32'h0000_7000, 64'h7, 8'd3);
        send_rsp(3'd0, '0, 64'h77);
        @(negedge clk);
        chk("R9", "held read rd_data", rd_data, 64'h77);

        // R11: data response during a write is an error; the write continues.
        send_seq(1'b1, 32'h0000_8000, 64'h8, 8'd1);
        repeat (REQ_LAT) @(negedge clk);
        send_rsp(3'd0, '0, 64'h99);
        @(negedge clk);
        chk("R11", "proto_err on mismatch", 64'(proto_err), 64'd1);
        chk("R11", "still busy", 64'(seq_ready), 64'd0);
        chk("R11", "no wr_done", 64'(wr_done), 64'd0);
        send_rsp(3'd3, '0, '0);
        repeat (2) @(negedge clk);
        chk("R11", "write completes after error", 64'(wr_done), 64'd1);
        chk("R11", "proto_err sticky", 64'(proto_err), 64'd1);
        repeat (RSP_LAT + 2) @(negedge clk);
        do_reset();

        // R10/R11: unknown kind races a load; response wins and is an error.
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = 3'd5; rsp_acks = '0;
        seq_valid = 1'b1; seq_is_store = 1'b0; seq_addr = 32'h0000_9000;
        seq_data = 64'h9; seq_len = 8'd5;
        #1;
        chk("R10", "rsp_ready", 64'(rsp_ready), 64'd1);
        chk("R10", "seq_ready blocked", 64'(seq_ready), 64'd0);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        @(negedge clk);
        chk("R11", "proto_err unknown kind", 64'(proto_err), 64'd1);
        chk("R11", "state stays idle", 64'(seq_ready), 64'd1);
        @(posedge clk); #1;
        seq_valid = 1'b0;
        chk_req("R10", 1'b0, 32'h0000_9000, 64'h9, 8'd5);
        send_rsp(3'd1, '0, 64'hAB);
        @(negedge clk);
        chk("R12", "one completion after error", 64'(rd_done), 64'd1);
        @(negedge clk);
        chk("R12", "no second completion", 64'(rd_done), 64'd0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule